// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port Controller

This block is the serial test port of a synchronous memory device. It follows the four-wire boundary-scan scheme: a test clock, a mode-select line that steers a sixteen-state controller, a serial data input and a serial data output. Inside are a 3-bit instruction register, a 1-bit pass-through register, a 32-bit identity register and a 75-bit boundary chain. The boundary cells capture from a parallel vector that stands in for the device pins. The cells also drive an update vector that stands in for the output latches of the pins.

The instruction set is specific to this device. Two instructions load the boundary chain and also raise a control output that puts the memory data pins into high impedance, so that the pins can be sampled with no interference from the memory core. A third instruction samples the pins and leaves them driven. Several codes, including one reserved code, fall back to the pass-through register. There is no separate test reset pin. The controller is reset by the power-up reset, or by holding the mode-select line high for five clocks.

Top module: `mem_tap`

## Requirements
- R1: While `rst_ni` is low, and after it rises, the controller sits in the reset state with instruction 001 (identity) active. `tdo_en_o` is 0, `pins_hiz_o` is 0 and `bscan_upd_o` is all zeros.
- R2: Five consecutive `tms_i` samples of 1 bring the controller to the reset state from any state. The next clock edge in that state makes 001 the active instruction again.
- R3: Capture-IR loads the pattern 001 into the instruction shift stage, so the first three bits shifted out of every instruction scan are 1, 0, 0.
- R4: Instruction 001 selects the identity register. It captures {revision[3:0], configuration[9:0], vendor-defined[5:0], manufacturer code[10:0], 1'b1}, with bit 0 a constant 1, and shifts it out LSB first.
- R5: Codes 011, 110, 111 and the reserved code 101 select the 1-bit pass-through register. It captures 0 and then passes `tdi_i` to TDO with one clock of delay.
- R6: `pins_hiz_o` is 1 exactly when the active instruction is 000 (external test) or 010 (sample with pins floated). It is 0 for 100 (sample) and every other code.
- R7: Codes 000, 010 and 100 select the 75-bit boundary chain. Capture-DR loads `pins_i`, which shifts out bit 0 first. Update-DR copies the shifted-in value to `bscan_upd_o`.
- R8: `tdo_en_o` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo_o` changes only on the falling edge of `tck_i`.
- R9: The active instruction, and with it `pins_hiz_o`, changes only on the clock edge leaving Update-IR or on a clock edge in the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| tms_i | input | 1 | Mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in, sampled on rising `tck_i` |
| pins_i | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo_o | output | 1 | Serial data out, launched on falling `tck_i` |
| tdo_en_o | output | 1 | Output enable for `tdo_o`; 0 means high impedance |
| pins_hiz_o | output | 1 | Forces the memory data pins to high impedance |
| bscan_upd_o | output | BSR_LEN | Boundary update stage driving the pin latches |

## Verification
The bench keeps the default 75-cell boundary chain, so every scan covers the full chain and its wrap from captured pins to shifted-in data. It overrides all four identity fields with non-zero, asymmetric values, so that a field placed at the wrong offset or in the wrong order shows up in the 32-bit capture. Every one of the eight instruction codes is loaded. The bench also leaves the controller in the middle of a data scan through the five-ones path, and applies a reset in the middle of the run.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_PASS, SEL_IDENT, SEL_CHAIN} dr_sel_e;

  localparam int unsigned INS_W = 3;
  localparam logic [INS_W-1:0] INS_EXT   = 3'b000;
  localparam logic [INS_W-1:0] INS_IDENT = 3'b001;
  localparam logic [INS_W-1:0] INS_SMPZ  = 3'b010;
  localparam logic [INS_W-1:0] INS_SMP   = 3'b100;
  localparam logic [INS_W-1:0] INS_CAPT  = 3'b001;

  function automatic tap_state_e next_state(tap_state_e s, logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
      default:   return ST_RESET;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= next_state(state_q, tms_i);
  end

  assign state_o = state_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic             tck_i,
  input  logic             rst_ni,
  input  tap_state_e       state_i,
  input  logic             tdi_i,
  output logic [INS_W-1:0] ir_o,
  output logic [INS_W-1:0] ir_sh_o,
  output dr_sel_e          sel_o,
  output logic             hiz_o
);
  logic [INS_W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= INS_CAPT;
      ir_q <= INS_IDENT;
    end else begin
      case (state_i)
        ST_CAP_IR: sh_q <= INS_CAPT;
        ST_SHF_IR: sh_q <= {tdi_i, sh_q[INS_W-1:1]};
        default:   sh_q <= sh_q;
      endcase
      if (state_i == ST_RESET)       ir_q <= INS_IDENT;
      else if (state_i == ST_UPD_IR) ir_q <= sh_q;
    end
  end

  always_comb begin
    sel_o = SEL_PASS;
    hiz_o = 1'b0;
    case (ir_q)
      INS_EXT:   begin sel_o = SEL_CHAIN; hiz_o = 1'b1; end
      INS_SMPZ:  begin sel_o = SEL_CHAIN; hiz_o = 1'b1; end
      INS_SMP:   sel_o = SEL_CHAIN;
      INS_IDENT: sel_o = SEL_IDENT;
      default:   sel_o = SEL_PASS;  // 011, 101, 110, 111
    endcase
  end

  assign ir_o    = ir_q;
  assign ir_sh_o = sh_q;
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int unsigned    BSR_LEN = 75,
  parameter logic [31:0]    ID_VAL  = 32'h1
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               so_o,
  output logic [BSR_LEN-1:0] upd_o
);
  localparam int unsigned ID_W = 32;

  logic               pass_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] chain_q, upd_q;

  wire cap = (state_i == ST_CAP_DR);
  wire shf = (state_i == ST_SHF_DR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q  <= 1'b0;
      id_q    <= ID_VAL;
      chain_q <= '0;
      upd_q   <= '0;
    end else begin
      if (cap) begin
        pass_q  <= 1'b0;
        id_q    <= ID_VAL;
        chain_q <= pins_i;
      end else if (shf) begin
        case (sel_i)
          SEL_IDENT: id_q    <= {tdi_i, id_q[ID_W-1:1]};
          SEL_CHAIN: chain_q <= {tdi_i, chain_q[BSR_LEN-1:1]};
          default:   pass_q  <= tdi_i;
        endcase
      end
      if (state_i == ST_UPD_DR && sel_i == SEL_CHAIN) upd_q <= chain_q;
    end
  end

  always_comb begin
    case (sel_i)
      SEL_IDENT: so_o = id_q[0];
      SEL_CHAIN: so_o = chain_q[0];
      default:   so_o = pass_q;
    endcase
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import tap_pkg::*;
#(
  parameter int unsigned BSR_LEN  = 75,
  parameter logic [3:0]  ID_REV   = 4'h1,
  parameter logic [9:0]  ID_CFG   = 10'h0E4,
  parameter logic [5:0]  ID_VEND  = 6'h00,
  parameter logic [10:0] ID_MFR   = 11'h04E
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               tdo_o,
  output logic               tdo_en_o,
  output logic               pins_hiz_o,
  output logic [BSR_LEN-1:0] bscan_upd_o
);
  localparam logic [31:0] ID_VAL = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};

  tap_state_e       state_q;
  logic [INS_W-1:0] ir_q, ir_sh;
  dr_sel_e          sel;
  logic             dr_so, tdo_q, en_q;

  tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(state_q));

  tap_ir u_ir (
    .tck_i, .rst_ni, .state_i(state_q), .tdi_i,
    .ir_o(ir_q), .ir_sh_o(ir_sh), .sel_o(sel), .hiz_o(pins_hiz_o)
  );

  tap_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
    .tck_i, .rst_ni, .state_i(state_q), .sel_i(sel), .tdi_i,
    .pins_i, .so_o(dr_so), .upd_o(bscan_upd_o)
  );

  // falling-edge launch of serial output
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= (state_q == ST_SHF_IR) ? ir_sh[0] : dr_so;
      en_q  <= (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = en_q;
endmodule

// File: rtl/mem_tap_chk.sv
module mem_tap_chk
  import tap_pkg::*;
(
  input logic             tck_i,
  input logic             rst_ni,
  input logic             tms_i,
  input tap_state_e       state_q,
  input logic [INS_W-1:0] ir_q,
  input logic [INS_W-1:0] ir_sh,
  input logic             tdo_en_o,
  input logic             pins_hiz_o
);
  logic [2:0] ones_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        ones_q <= '0;
    else if (!tms_i)    ones_q <= '0;
    else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
  end

  p_five_ones_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state_q == ST_RESET));

  p_reset_ident_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_RESET) |=> (ir_q == INS_IDENT));

  p_capture_pat_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_CAP_IR) |=> (ir_sh == 3'b001));

  p_hiz_codes_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    pins_hiz_o |-> (!ir_q[0] && !ir_q[2]));

  p_ir_hold_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q != ST_UPD_IR && state_q != ST_RESET) |=> ($stable(ir_q) && $stable(pins_hiz_o)));

  p_tdo_en_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (state_q == ST_SHF_DR || state_q == ST_SHF_IR));
endmodule

bind mem_tap mem_tap_chk u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .state_q(state_q),
  .ir_q(ir_q), .ir_sh(ir_sh), .tdo_en_o(tdo_en_o), .pins_hiz_o(pins_hiz_o)
);

// File: tb/tb_mem_tap.sv
`timescale 1ns/1ps
module tb_mem_tap;
  localparam int unsigned BSR = 75;
  localparam logic [3:0]  T_REV  = 4'h5;
  localparam logic [9:0]  T_CFG  = 10'h2C7;
  localparam logic [5:0]  T_VEND = 6'h2A;
  localparam logic [10:0] T_MFR  = 11'h3B1;
  localparam logic [31:0] T_ID   = {T_REV, T_CFG, T_VEND, T_MFR, 1'b1};

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic [BSR-1:0] pins = '0;
  logic tdo, tdo_en, hiz;
  logic [BSR-1:0] upd;

  always #2 tck = ~tck;

  mem_tap #(.BSR_LEN(BSR), .ID_REV(T_REV), .ID_CFG(T_CFG), .ID_VEND(T_VEND), .ID_MFR(T_MFR)) dut (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .pins_i(pins),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .pins_hiz_o(hiz), .bscan_upd_o(upd)
  );

  typedef struct { logic b; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic mon_on = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compares every shifted-out bit against the scoreboard
  initial begin
    forever begin
      @(negedge tck); #1.5;
      if (mon_on && tdo_en) begin
        logic v;
        v = tdo;
        if (q.size() == 0) chk(1'b0, "R8 unexpected shift", {127'b0, v}, 128'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(v === e.b, e.tag, {127'b0, v}, {127'b0, e.b});
        end
        @(posedge tck); #0.5;
        chk(tdo === v, "R8 tdo held across rising edge", {127'b0, tdo}, {127'b0, v});
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic ir_scan(input logic [2:0] code);
    q.push_back('{1'b1, "R3 capture bit0"});
    q.push_back('{1'b0, "R3 capture bit1"});
    q.push_back('{1'b0, "R3 capture bit2"});
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    step(1, 0); step(0, 0);
  endtask

  // drive n bits; reg of length len captured cap; expected out is cap then din delayed
  task automatic dr_scan(input int n, input int len, input logic [127:0] cap,
                         input logic [127:0] din, input string tag);
    for (int i = 0; i < n; i++)
      q.push_back('{(i < len) ? cap[i] : din[i-len], tag});
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n-1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [BSR-1:0] pat(input int s);
    logic [BSR-1:0] r;
    for (int i = 0; i < BSR; i++) r[i] = (((i * 7 + s) % 5) < 2);
    return r;
  endfunction

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 128'h0, 128'h1);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] d;
    #5;
    chk(tdo_en === 1'b0, "R1 tdo_en in reset", {127'b0, tdo_en}, 128'h0);
    chk(hiz === 1'b0, "R1 hiz in reset", {127'b0, hiz}, 128'h0);
    chk(upd === '0, "R1 upd in reset", {53'b0, upd}, 128'h0);
    @(negedge tck); rst_n = 1'b1;
    step(0, 0);
    chk(tdo_en === 1'b0, "R8 tdo_en idle", {127'b0, tdo_en}, 128'h0);

    // R1/R4: identity after reset, plus tdi pass-through afterwards
    d = 128'hA;
    dr_scan(36, 32, {96'b0, T_ID}, d, "R4 identity stream");

    // R5: all pass-through codes
    ir_scan(3'b011);
    chk(hiz === 1'b0, "R6 hiz for 011", {127'b0, hiz}, 128'h0);
    dr_scan(8, 1, 128'h0, 128'hB5, "R5 pass 011");
    ir_scan(3'b110);
    dr_scan(8, 1, 128'h0, 128'h4C, "R5 pass 110");
    ir_scan(3'b111);
    dr_scan(8, 1, 128'h0, 128'hF1, "R5 pass 111");
    ir_scan(3'b101);
    chk(hiz === 1'b0, "R6 hiz for 101", {127'b0, hiz}, 128'h0);
    dr_scan(8, 1, 128'h0, 128'h3A, "R5 pass 101");

    // R7: sample keeps pins driven
    ir_scan(3'b100);
    chk(hiz === 1'b0, "R6 hiz for 100", {127'b0, hiz}, 128'h0);
    pins = pat(1);
    d = {53'b0, pat(3)};
    dr_scan(BSR, BSR, {53'b0, pat(1)}, d, "R7 sample chain");
    chk(upd === pat(3), "R7 update after sample", {53'b0, upd}, {53'b0, pat(3)});

    // R6/R7: sample with pins floated
    ir_scan(3'b010);
    chk(hiz === 1'b1, "R6 hiz for 010", {127'b0, hiz}, 128'h1);
    pins = pat(2);
    d = {53'b0, pat(4)};
    dr_scan(BSR + 4, BSR, {53'b0, pat(2)}, d, "R7 floated sample chain");
    chk(hiz === 1'b1, "R9 hiz held over DR scan", {127'b0, hiz}, 128'h1);

    // external test
    ir_scan(3'b000);
    chk(hiz === 1'b1, "R6 hiz for 000", {127'b0, hiz}, 128'h1);
    pins = pat(0);
    d = {53'b0, pat(2)};
    dr_scan(BSR, BSR, {53'b0, pat(0)}, d, "R7 external chain");
    chk(upd === pat(2), "R7 update after external", {53'b0, upd}, {53'b0, pat(2)});

    // R2: leave Shift-DR with five ones
    q.push_back('{pins[0], "R2 one bit before escape"});
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 1);
    chk(hiz === 1'b1, "R9 hiz before reset-state edge", {127'b0, hiz}, 128'h1);
    step(0, 0);
    chk(hiz === 1'b0, "R2 hiz after five ones", {127'b0, hiz}, 128'h0);
    dr_scan(32, 32, {96'b0, T_ID}, 128'h0, "R2 identity after five ones");

    // R1: reset in mid-run
    ir_scan(3'b000);
    @(negedge tck); #1; rst_n = 1'b0; #1;
    chk(hiz === 1'b0, "R1 hiz on mid reset", {127'b0, hiz}, 128'h0);
    chk(upd === '0, "R1 upd on mid reset", {53'b0, upd}, 128'h0);
    @(negedge tck); #1; rst_n = 1'b1;
    step(0, 0);
    dr_scan(32, 32, {96'b0, T_ID}, 128'h0, "R1 identity after reset");

    repeat (3) @(posedge tck);
    chk(q.size() == 0, "scoreboard drained", q.size(), 128'h0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule